// File: doc/BRIEF.md
# Banked Scratchpad Conflict Scheduler

This block is the local scratchpad of one SIMD engine. It holds its words in a set of independent banks and accepts, in one cycle, a whole vector of lane requests. Each lane may read a word, write a word, or run an integer atomic on a word. The low address bits choose the bank, and the remaining bits choose the word inside that bank. Lanes that land in distinct banks are all served together in a single pass.

When several lanes hit one bank at different words, the block replays the request over further passes, one word per bank per pass. Reads of the very same word are merged into one broadcast pass. Writes to one word from several lanes are merged into one pass as well. Atomics are done read-modify-write inside the bank, one lane at a time, and each lane gets back the value the word held before its own operation.

The block raises `busy` from the cycle after a request is taken until the last lane has been served. Each lane gets a one-cycle response strobe carrying the word's contents from just before the pass that served it.

Top module: `scr_bank_sched`

## Requirements
- R1: A lane address splits into bank = addr[4:0] and word-in-bank = addr[8:5] with the default geometry (8 lanes, 32 banks, 16 words per bank). A request whose enabled lanes all use different banks completes in one pass, so `busy` is high for exactly one cycle.
- R2: Lanes that hit one bank at different words are served over several passes. In each pass a bank serves the word of its lowest-numbered pending lane. `busy` stays high for as many cycles as the busiest bank needs passes.
- R3: All pending reads of the same word in one bank are served in the same pass as a broadcast, and they all get the same data.
- R4: All pending writes to the same word are served in one pass. The stored value is the write data of the highest-numbered of those lanes.
- R5: Atomic opcodes are 2 add, 3 signed minimum, 4 signed maximum, 5 AND, 6 OR, 7 XOR and 8 exchange, all on 32-bit integers. Each atomic lane is served alone in its bank's pass, in lane order, and returns the word's value from before its own operation. Atomics on distinct banks share one pass.
- R6: A request is taken only on a clock edge where `req_valid` is high and `busy` is low. A request presented while `busy` is high has no effect on storage or on responses.
- R7: Each enabled lane gets exactly one `rsp_valid` pulse of one cycle, in the cycle after the pass that served it. Its `rsp_data` is the word's value from before that pass, and this holds for writes too.
- R8: After a synchronous active-high reset, `busy` and `rsp_valid` are low and every stored word is zero.
- R9: A lane whose `lane_en` bit is low gets no response and changes no storage.
- R10: Opcode 0 is a read and opcode 1 is a write. Opcodes 9 to 15 behave as reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request vector is presented |
| lane_en | input | LANES | Per-lane enable |
| lane_op | input | LANES*4 | Per-lane opcode, lane l at bits [4l+3:4l] |
| lane_addr | input | LANES*ADDR_W | Per-lane word address, lane l at bits [l*ADDR_W +: ADDR_W] |
| lane_wdata | input | LANES*32 | Per-lane write data or atomic operand |
| busy | output | 1 | Request in progress; a new request is not taken |
| rsp_valid | output | LANES | Per-lane response strobe |
| rsp_data | output | LANES*32 | Per-lane value from before the serving pass |

## Verification
The embedded assertions watch, on every cycle, the properties that depend only on the flow of pending lanes. While busy, at least one lane retires each cycle. No lane is added while busy. A response appears only for a lane that was pending. No lane's strobe lasts longer than one cycle. Only the bench's scenarios can show the data outcomes: the lane-order replay schedule, the broadcast merge, highest-lane write priority, signed atomic arithmetic with its returned pre-values, the effect of a dropped request, and the effect of disabled lanes. The bench checks each of these against a reference memory it keeps itself.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int DW  = 32;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_RD   = 4'd0,
        OP_WR   = 4'd1,
        OP_ADD  = 4'd2,
        OP_SMIN = 4'd3,
        OP_SMAX = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_XCHG = 4'd8
    } scr_op_e;

    typedef enum logic [1:0] {
        CLS_RD  = 2'd0,
        CLS_WR  = 2'd1,
        CLS_AMO = 2'd2
    } op_cls_e;

    // Codes beyond the defined set fall back to a plain read (R10)
    function automatic scr_op_e op_norm(input logic [OPW-1:0] raw);
        if (raw > 4'd8) return OP_RD;
        return scr_op_e'(raw);
    endfunction

    function automatic op_cls_e op_class(input scr_op_e op);
        case (op)
            OP_RD:   return CLS_RD;
            OP_WR:   return CLS_WR;
            default: return CLS_AMO;
        endcase
    endfunction

    // New word value produced by an atomic (R5)
    function automatic logic [DW-1:0] amo_apply(input scr_op_e op,
                                                input logic [DW-1:0] old,
                                                input logic [DW-1:0] opnd);
        case (op)
            OP_ADD:  return old + opnd;
            OP_SMIN: return ($signed(old) < $signed(opnd)) ? old : opnd;
            OP_SMAX: return ($signed(old) > $signed(opnd)) ? old : opnd;
            OP_AND:  return old & opnd;
            OP_OR:   return old | opnd;
            OP_XOR:  return old ^ opnd;
            OP_XCHG: return opnd;
            default: return old;
        endcase
    endfunction

endpackage

// File: rtl/scr_bank_pick.sv
module scr_bank_pick
    import scr_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int BANK_W  = 5,
    parameter int WORD_W  = 4,
    parameter int BANK_ID = 0,
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0]             pend,
    input  logic [LANES-1:0][BANK_W-1:0] l_bank,
    input  logic [LANES-1:0][WORD_W-1:0] l_word,
    input  logic [LANES-1:0][OPW-1:0]    l_op,
    input  logic [LANES-1:0][DW-1:0]     l_wdata,
    output logic [LANES-1:0]             grant,
    output logic                         act,
    output logic [WORD_W-1:0]            act_word,
    output scr_op_e                      act_op,
    output logic [DW-1:0]                act_data
);

    logic [LANES-1:0]  hit;
    logic [LIDX_W-1:0] lead;
    logic [LIDX_W-1:0] win;
    op_cls_e           lcls;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            hit[l] = pend[l] && (l_bank[l] == BANK_W'(BANK_ID));
        end

        // lowest pending lane in this bank leads the pass (R2)
        act  = 1'b0;
        lead = '0;
        for (int l = 0; l < LANES; l++) begin
            if (hit[l] && !act) begin
                act  = 1'b1;
                lead = LIDX_W'(l);
            end
        end

        act_word = l_word[lead];
        act_op   = scr_op_e'(l_op[lead]);
        lcls     = op_class(act_op);

        // same word and same kind join the leader; atomics go alone (R3, R4, R5)
        grant = '0;
        for (int l = 0; l < LANES; l++) begin
            if (hit[l] && (l_word[l] == act_word)) begin
                if (lcls == CLS_AMO) begin
                    grant[l] = (LIDX_W'(l) == lead);
                end else begin
                    grant[l] = (op_class(scr_op_e'(l_op[l])) == lcls);
                end
            end
        end

        // highest granted lane supplies the data (R4)
        win = lead;
        for (int l = 0; l < LANES; l++) begin
            if (grant[l]) win = LIDX_W'(l);
        end
        act_data = l_wdata[win];
    end

endmodule

// File: rtl/scr_bank_mem.sv
module scr_bank_mem
    import scr_pkg::*;
#(
    parameter int WORD_W = 4,
    localparam int DEPTH = 1 << WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic [WORD_W-1:0] act_word,
    input  scr_op_e           act_op,
    input  logic [DW-1:0]     act_data,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] mem [DEPTH];

    // value before this pass, returned to every served lane (R7)
    assign rdata = mem[act_word];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (act && (act_op != OP_RD)) begin
            if (act_op == OP_WR) begin
                mem[act_word] <= act_data;
            end else begin
                mem[act_word] <= amo_apply(act_op, mem[act_word], act_data);
            end
        end
    end

endmodule

// File: rtl/scr_bank_sched.sv
module scr_bank_sched
    import scr_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int NUM_BANKS = 32,
    parameter int WORD_W    = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ADDR_W   = BANK_W + WORD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [LANES-1:0]      lane_en,
    input  logic [LANES*OPW-1:0]  lane_op,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES*DW-1:0]   lane_wdata,
    output logic                  busy,
    output logic [LANES-1:0]      rsp_valid,
    output logic [LANES*DW-1:0]   rsp_data
);

    logic [LANES-1:0][OPW-1:0]    in_op;
    logic [LANES-1:0][ADDR_W-1:0] in_addr;
    logic [LANES-1:0][DW-1:0]     in_wdata;

    logic [LANES-1:0]             pend;
    logic [LANES-1:0][OPW-1:0]    q_op;
    logic [LANES-1:0][ADDR_W-1:0] q_addr;
    logic [LANES-1:0][DW-1:0]     q_wdata;

    logic [LANES-1:0][BANK_W-1:0] l_bank;
    logic [LANES-1:0][WORD_W-1:0] l_word;
    logic [LANES-1:0][DW-1:0]     lane_rdata;
    logic [LANES-1:0][DW-1:0]     rsp_q;

    logic [NUM_BANKS-1:0][LANES-1:0] grant_b;
    logic [NUM_BANKS-1:0][DW-1:0]    bank_rdata;
    logic [LANES-1:0]                served;

    assign in_op    = lane_op;
    assign in_addr  = lane_addr;
    assign in_wdata = lane_wdata;
    assign busy     = |pend;
    assign rsp_data = rsp_q;

    // address split: low bits pick the bank (R1)
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            l_bank[l]     = q_addr[l][BANK_W-1:0];
            l_word[l]     = q_addr[l][ADDR_W-1:BANK_W];
            lane_rdata[l] = bank_rdata[l_bank[l]];
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              act;
        logic [WORD_W-1:0] act_word;
        scr_op_e           act_op;
        logic [DW-1:0]     act_data;

        scr_bank_pick #(
            .LANES  (LANES),
            .BANK_W (BANK_W),
            .WORD_W (WORD_W),
            .BANK_ID(b)
        ) pick_i (
            .pend    (pend),
            .l_bank  (l_bank),
            .l_word  (l_word),
            .l_op    (q_op),
            .l_wdata (q_wdata),
            .grant   (grant_b[b]),
            .act     (act),
            .act_word(act_word),
            .act_op  (act_op),
            .act_data(act_data)
        );

        scr_bank_mem #(
            .WORD_W(WORD_W)
        ) mem_i (
            .clk     (clk),
            .rst     (rst),
            .act     (act),
            .act_word(act_word),
            .act_op  (act_op),
            .act_data(act_data),
            .rdata   (bank_rdata[b])
        );
    end

    always_comb begin
        served = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            served = served | grant_b[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            rsp_valid <= '0;
            rsp_q     <= '0;
            q_op      <= '0;
            q_addr    <= '0;
            q_wdata   <= '0;
        end else begin
            rsp_valid <= served;
            for (int l = 0; l < LANES; l++) begin
                if (served[l]) rsp_q[l] <= lane_rdata[l];
            end
            if (req_valid && !busy) begin
                pend <= lane_en;
                for (int l = 0; l < LANES; l++) begin
                    q_op[l]    <= op_norm(in_op[l]);
                    q_addr[l]  <= in_addr[l];
                    q_wdata[l] <= in_wdata[l];
                end
            end else begin
                pend <= pend & ~served;
            end
        end
    end

    // every busy cycle retires at least one lane (R2)
    p_progress_r2: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($countones(pend) < $countones($past(pend))));

    // nothing joins the pending set while busy (R6)
    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((pend & ~$past(pend)) == '0));

    // a strobe only for a lane that was pending (R7)
    p_rsp_pending_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rsp_valid & ~$past(pend)) == '0));

    // strobes last one cycle (R7)
    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rsp_valid & $past(rsp_valid)) == '0));

endmodule

// File: tb/scr_bank_sched_tb.sv
module scr_bank_sched_tb_top;

    localparam int LANES  = 8;
    localparam int NBANK  = 32;
    localparam int WORD_W = 4;
    localparam int ADDR_W = 9;
    localparam int NWORDS = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [LANES-1:0] lane_en = '0;
    logic [LANES*4-1:0] lane_op = '0;
    logic [LANES*ADDR_W-1:0] lane_addr = '0;
    logic [LANES*32-1:0] lane_wdata = '0;
    logic busy;
    logic [LANES-1:0] rsp_valid;
    logic [LANES*32-1:0] rsp_data;

    always #2.5 clk = ~clk;

    scr_bank_sched #(.LANES(LANES), .NUM_BANKS(NBANK), .WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .lane_en(lane_en),
        .lane_op(lane_op), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    logic [31:0] ref_mem [NWORDS];
    bit   [LANES-1:0] t_en;
    logic [3:0]  t_op   [LANES];
    logic [8:0]  t_addr [LANES];
    logic [31:0] t_wd   [LANES];
    int          exp_pass [LANES];
    logic [31:0] exp_data [LANES];
    int          exp_passes;

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic int cls_of(input logic [3:0] op);
        if (op == 4'd1) return 1;
        if (op >= 4'd2 && op <= 4'd8) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] amo_ref(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            4'd2: return a + b;
            4'd3: return ($signed(a) < $signed(b)) ? a : b;
            4'd4: return ($signed(a) > $signed(b)) ? a : b;
            4'd5: return a & b;
            4'd6: return a | b;
            4'd7: return a ^ b;
            default: return b;
        endcase
    endfunction

    // expected schedule and data from the stated pass rules
    task automatic model();
        bit done [LANES];
        exp_passes = 0;
        for (int l = 0; l < LANES; l++) begin done[l] = 0; exp_pass[l] = -1; exp_data[l] = '0; end
        for (int b = 0; b < NBANK; b++) begin
            int g = 0;
            for (int l = 0; l < LANES; l++) begin
                if (t_en[l] && !done[l] && int'(t_addr[l][4:0]) == b) begin
                    int c = cls_of(t_op[l]);
                    logic [31:0] pre = ref_mem[t_addr[l]];
                    int lastw = l;
                    g++;
                    for (int m = l; m < LANES; m++) begin
                        if (t_en[m] && !done[m] && t_addr[m] == t_addr[l] &&
                            ((c == 2) ? (m == l) : (cls_of(t_op[m]) == c))) begin
                            done[m] = 1; exp_pass[m] = g; exp_data[m] = pre; lastw = m;
                        end
                    end
                    if (c == 1) ref_mem[t_addr[l]] = t_wd[lastw];
                    if (c == 2) ref_mem[t_addr[l]] = amo_ref(t_op[l], pre, t_wd[l]);
                end
            end
            if (g > exp_passes) exp_passes = g;
        end
    endtask

    task automatic issue(input string tag, input bit distract);
        int got_pass [LANES];
        logic [31:0] got_data [LANES];
        int nbusy = 0;
        int j = 0;
        int dup = 0;
        model();
        @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            lane_op[l*4 +: 4] = t_op[l];
            lane_addr[l*ADDR_W +: ADDR_W] = t_addr[l];
            lane_wdata[l*32 +: 32] = t_wd[l];
            got_pass[l] = -1; got_data[l] = '0;
        end
        lane_en = t_en;
        req_valid = 1'b1;
        @(posedge clk);
        do begin
            @(negedge clk);
            if (j == 0) begin
                if (distract && busy) begin
                    lane_en = '1;
                    for (int l = 0; l < LANES; l++) begin
                        lane_op[l*4 +: 4] = 4'd1;
                        lane_addr[l*ADDR_W +: ADDR_W] = 9'(l * 33);
                        lane_wdata[l*32 +: 32] = 32'hDEAD_0000 + l;
                    end
                end else req_valid = 1'b0;
            end
            if (!busy) req_valid = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                if (rsp_valid[l]) begin
                    if (got_pass[l] != -1) dup++;
                    got_pass[l] = j;
                    got_data[l] = rsp_data[l*32 +: 32];
                end
            end
            if (busy) nbusy++;
            j++;
        end while (busy && j < 100);
        chk(tag, "pass count", nbusy, exp_passes);
        chk(tag, "duplicate strobes", dup, 0);
        for (int l = 0; l < LANES; l++) begin
            chk(tag, $sformatf("lane %0d pass", l), got_pass[l], exp_pass[l]);
            if (t_en[l]) chk(tag, $sformatf("lane %0d data", l), got_data[l], exp_data[l]);
        end
    endtask

    task automatic set_lane(input int l, input logic [3:0] op, input int a, input logic [31:0] wd);
        t_en[l] = 1'b1; t_op[l] = op; t_addr[l] = 9'(a); t_wd[l] = wd;
    endtask

    task automatic clear_req();
        t_en = '0;
        for (int l = 0; l < LANES; l++) begin t_op[l] = 4'd0; t_addr[l] = '0; t_wd[l] = '0; end
    endtask

    task automatic read_one(input string tag, input int a);
        clear_req();
        set_lane(0, 4'd0, a, 32'h0);
        issue(tag, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NWORDS; i++) ref_mem[i] = '0;
        clear_req();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8", "busy after reset", busy, 0);
        chk("R8", "rsp_valid after reset", rsp_valid, 0);

        // R8: every word reads zero after reset; R1: eight consecutive addresses in one pass
        for (int base = 0; base < NWORDS; base += LANES) begin
            clear_req();
            for (int l = 0; l < LANES; l++) set_lane(l, 4'd0, base + l, 32'h0);
            issue("R8", 1'b0);
        end
        // R1: fill every word, then read back
        for (int base = 0; base < NWORDS; base += LANES) begin
            clear_req();
            for (int l = 0; l < LANES; l++) set_lane(l, 4'd1, base + l, 32'((base + l) * 32'h9E37_79B1) ^ 32'h5A5A);
            issue("R1", 1'b0);
        end
        for (int base = 0; base < NWORDS; base += LANES) begin
            clear_req();
            for (int l = 0; l < LANES; l++) set_lane(l, 4'd0, base + l, 32'h0);
            issue("R1", 1'b0);
        end
        // R7: a write returns the old contents
        for (int base = 0; base < 64; base += LANES) begin
            clear_req();
            for (int l = 0; l < LANES; l++) set_lane(l, 4'd1, base + l, 32'h1000 + base + l);
            issue("R7", 1'b0);
        end

        // R2: k lanes in one bank at different words need k passes, lowest lane first
        for (int k = 1; k <= LANES; k++) begin
            clear_req();
            for (int l = 0; l < k; l++) set_lane(l, 4'd0, 7 + 32 * ((l * 5 + 3) % 16), 32'h0);
            issue("R2", 1'b0);
            clear_req();
            for (int l = 0; l < k; l++) set_lane(l, 4'd1, 19 + 32 * (15 - l), 32'h2000 + k * 16 + l);
            issue("R2", 1'b0);
        end
        clear_req();
        set_lane(0, 4'd0, 1 + 32 * 2, 0); set_lane(2, 4'd0, 1 + 32 * 9, 0); set_lane(4, 4'd0, 1 + 32 * 4, 0);
        set_lane(1, 4'd0, 2 + 32 * 3, 0); set_lane(3, 4'd0, 2 + 32 * 8, 0);
        issue("R2", 1'b0);

        // R3: broadcast reads
        clear_req();
        for (int l = 0; l < LANES; l++) set_lane(l, 4'd0, 100, 0);
        issue("R3", 1'b0);
        clear_req();
        for (int l = 0; l < LANES; l++) set_lane(l, 4'd0, (l < 4) ? (5 + 32 * 1) : (5 + 32 * 12), 0);
        issue("R3", 1'b0);
        clear_req();
        for (int l = 1; l < 7; l++) set_lane(l, 4'd0, 40 + l, 0);
        set_lane(0, 4'd0, 300, 0); set_lane(7, 4'd0, 300, 0);
        issue("R3", 1'b0);

        // R4: merged writes, highest lane wins
        clear_req();
        for (int l = 0; l < LANES; l++) set_lane(l, 4'd1, 200, 32'(l + 1));
        issue("R4", 1'b0);
        read_one("R4", 200);
        clear_req();
        for (int l = 0; l < LANES; l++) set_lane(l, 4'd1, (l % 2 == 0) ? (9 + 32 * 3) : (9 + 32 * 6), 32'h300 + l);
        issue("R4", 1'b0);
        read_one("R4", 9 + 32 * 3);
        read_one("R4", 9 + 32 * 6);

        // R5: each atomic opcode, all lanes on one word, then on distinct banks
        for (int op = 2; op <= 8; op++) begin
            clear_req();
            set_lane(0, 4'd1, 333, 32'hFFFF_FFF0);
            issue("R5", 1'b0);
            clear_req();
            for (int l = 0; l < LANES; l++) set_lane(l, 4'(op), 333, 32'(l * 37 - 100));
            issue("R5", 1'b0);
            read_one("R5", 333);
            clear_req();
            for (int l = 0; l < LANES; l++) set_lane(l, 4'(op), 64 + l * 3, 32'(l * 1234 + 7));
            issue("R5", 1'b0);
        end

        // R6: request offered while busy is dropped
        clear_req();
        for (int l = 0; l < 4; l++) set_lane(l, 4'd0, 11 + 32 * l, 0);
        issue("R6", 1'b1);
        for (int l = 0; l < LANES; l++) read_one("R6", l * 33);

        // R9: disabled lanes neither respond nor write
        clear_req();
        for (int l = 0; l < LANES; l++) set_lane(l, 4'd1, 400 + l, 32'hBEEF_0000 + l);
        t_en = 8'b1010_0101;
        issue("R9", 1'b0);
        for (int l = 0; l < LANES; l++) read_one("R9", 400 + l);

        // R10: undefined opcodes act as reads
        clear_req();
        for (int l = 0; l < LANES; l++) set_lane(l, 4'(9 + (l % 7)), 480 + l, 32'hFFFF_FFFF);
        issue("R10", 1'b0);
        for (int l = 0; l < LANES; l++) read_one("R10", 480 + l);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule